// File: doc/BRIEF.md
# Three-Axis Sample Cube Rotation Engine

This engine reorders a three-dimensional cube of complex samples between two successive FFT passes. The source cube is stored with dimensions DIM0 x DIM1 x DIM2, with DIM2 innermost. The engine copies it into a separate destination region in one of two rotated axis orders, so that the vectors the next FFT pass needs become contiguous. The destination is written in strictly ascending address order. The reads jump through the source with the strides that this order implies.

Software or a sequencer loads the two base addresses and the rotation mode and pulses start. The engine then moves one 64-bit word (one complex sample, two single-precision values) per cycle in which the memory is ready. It pulses done once the last word is written. The engine runs only while no FFT pass is active, and the two regions must not overlap.

With the default sizes, forward rotation turns a 12 x 512 x 32 cube into 512 x 32 x 12, so the innermost axis holds one sample per virtual antenna. Backward rotation performs the inverse axis cycle.

Top module: `cube_rotate_engine`

## Requirements
- R1: While reset is held and while idle, busy, done, rd_en and wr_en are all 0.
- R2: A start pulse while idle latches mode, src_base and dst_base. In the next cycle busy is 1 and rd_addr equals the latched src_base, with rd_en high if mem_ready is high.
- R3: With mode 0 (forward), the source word at offset (i*DIM1+j)*DIM2+k is written to destination offset (j*DIM2+k)*DIM0+i.
- R4: With mode 1 (backward), the source word at offset (i*DIM1+j)*DIM2+k is written to destination offset (k*DIM0+i)*DIM1+j.
- R5: The engine writes exactly DIM0*DIM1*DIM2 words, to dst_base, dst_base+1 and so on in ascending order. No word outside that range is written.
- R6: Each write carries the rd_data returned by the read accepted in the previous ready cycle. The source region is left unchanged.
- R7: While mem_ready is 0, rd_en and wr_en stay 0 and the engine holds its position. The transfer then completes without losing or repeating a word.
- R8: done is high for exactly one cycle, in the cycle after the last write, and busy is 0 from that cycle on.
- R9: A start pulse while busy is ignored. Mode and base addresses keep their latched values.
- R10: With mem_ready held at 1, done rises exactly N+2 cycles after the start cycle, where N = DIM0*DIM1*DIM2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a rotation (sampled only while idle) |
| mode | input | 1 | 0 forward rotation, 1 backward rotation |
| src_base | input | AW | Word address of the source cube |
| dst_base | input | AW | Word address of the destination cube |
| busy | output | 1 | Rotation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_ready | input | 1 | Memory accepts requests this cycle |
| rd_en | output | 1 | Read request, accepted at the clock edge |
| rd_addr | output | AW | Read word address |
| rd_data | input | DW | Read data, valid the cycle after an accepted read and held until the next one |
| wr_en | output | 1 | Write request, accepted at the clock edge |
| wr_addr | output | AW | Write word address |
| wr_data | output | DW | Write data |

## Verification
The first read address is due in the cycle right after the start cycle. With no stalls, the last write falls in cycle N+1 and done falls in cycle N+2, counted from the start cycle. The bench drives inputs one time step after the rising edge and samples on the falling edge. It counts falling edges from the start cycle and compares that count with N+2 exactly. The destination contents, the guard words on either side of the destination and a source word are read from the memory model only after done has been seen, when every write has settled. Stall runs check the same contents, and a monitor checks on every falling edge that no request appears while mem_ready is low.

// File: rtl/cube_rot_pkg.sv
package cube_rot_pkg;

   // Axis order produced in the destination region
   typedef enum logic {
      ROT_FWD = 1'b0,   // (D0,D1,D2) -> (D1,D2,D0)
      ROT_BWD = 1'b1    // (D0,D1,D2) -> (D2,D0,D1)
   } rot_mode_e;

   localparam int unsigned CUBE_AXES = 3;

endpackage

// File: rtl/cube_walk.sv
// Nested index counters walking the destination order; emits the source offset.
module cube_walk
   import cube_rot_pkg::*;
#(
   parameter int unsigned D0 = 12,
   parameter int unsigned D1 = 512,
   parameter int unsigned D2 = 32,
   parameter int unsigned IW = 9,
   parameter int unsigned OW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          step,
   input  rot_mode_e     mode,
   output logic [OW-1:0] src_off,
   output logic          last
);

   localparam logic [IW-1:0] M0    = IW'(D0 - 1);
   localparam logic [IW-1:0] M1    = IW'(D1 - 1);
   localparam logic [IW-1:0] M2    = IW'(D2 - 1);
   localparam logic [OW-1:0] STR_I = OW'(D1 * D2);
   localparam logic [OW-1:0] STR_J = OW'(D2);

   logic [CUBE_AXES-1:0][IW-1:0] lim_m1;
   logic [CUBE_AXES-1:0][IW-1:0] cnt;
   logic [CUBE_AXES-1:0]         at_max;
   logic [CUBE_AXES-1:0]         carry;
   logic [IW-1:0]                ii, jj, kk;

   // level 0 is innermost (fastest) in destination order
   always_comb begin
      if (mode == ROT_FWD) begin
         lim_m1[0] = M0;
         lim_m1[1] = M2;
         lim_m1[2] = M1;
      end else begin
         lim_m1[0] = M1;
         lim_m1[1] = M0;
         lim_m1[2] = M2;
      end
   end

   assign carry[0] = step;

   for (genvar l = 0; l < CUBE_AXES; l++) begin : g_lvl
      logic [IW-1:0] val_q;

      assign at_max[l] = (val_q == lim_m1[l]);
      assign cnt[l]    = val_q;

      if (l < CUBE_AXES - 1) begin : g_carry
         assign carry[l+1] = carry[l] & at_max[l];
      end

      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            val_q <= '0;
         end else if (carry[l]) begin
            val_q <= at_max[l] ? '0 : val_q + 1'b1;
         end
      end
   end

   assign last = &at_max;

   always_comb begin
      if (mode == ROT_FWD) begin
         ii = cnt[0];
         kk = cnt[1];
         jj = cnt[2];
      end else begin
         jj = cnt[0];
         ii = cnt[1];
         kk = cnt[2];
      end
   end

   assign src_off = OW'(ii) * STR_I + OW'(jj) * STR_J + OW'(kk);

   // indices never leave their axis range while stepping
   p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (ii <= M0 && jj <= M1 && kk <= M2));

   // offset always inside the source cube
   p_off_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (32'(src_off) < D0 * D1 * D2));

endmodule

// File: rtl/cube_wr_stage.sv
// Write side: pairs returned read data with the next sequential destination slot.
module cube_wr_stage #(
   parameter int unsigned AW = 32,
   parameter int unsigned OW = 18,
   parameter int unsigned DW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          mem_ready,
   input  logic          rd_fire,
   input  logic          rd_last,
   input  logic [AW-1:0] dst_base,
   input  logic [DW-1:0] rd_data,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          fin
);

   logic          pend_q;
   logic          pend_last_q;
   logic [OW-1:0] dst_cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         pend_q      <= 1'b0;
         pend_last_q <= 1'b0;
         dst_cnt_q   <= '0;
      end else if (mem_ready) begin
         pend_q      <= rd_fire;
         pend_last_q <= rd_fire & rd_last;
         if (pend_q) begin
            dst_cnt_q <= dst_cnt_q + 1'b1;
         end
      end
   end

   assign wr_en   = pend_q & mem_ready;
   assign wr_addr = dst_base + AW'(dst_cnt_q);
   assign wr_data = rd_data;
   assign fin     = wr_en & pend_last_q;

   // checker state: previous accepted write address
   logic [AW-1:0] prev_q;
   logic          have_prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         prev_q      <= '0;
         have_prev_q <= 1'b0;
      end else if (wr_en) begin
         prev_q      <= wr_addr;
         have_prev_q <= 1'b1;
      end
   end

   p_dst_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && have_prev_q) |-> (wr_addr == prev_q + 1'b1));

   p_wr_needs_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ready && pend_q) |=> pend_q);

endmodule

// File: rtl/cube_rotate_engine.sv
module cube_rotate_engine
   import cube_rot_pkg::*;
#(
   parameter int unsigned DIM0 = 12,
   parameter int unsigned DIM1 = 512,
   parameter int unsigned DIM2 = 32,
   parameter int unsigned AW   = 32,
   parameter int unsigned DW   = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          mode,
   input  logic [AW-1:0] src_base,
   input  logic [AW-1:0] dst_base,
   output logic          busy,
   output logic          done,
   input  logic          mem_ready,
   output logic          rd_en,
   output logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] rd_data,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data
);

   localparam int unsigned N     = DIM0 * DIM1 * DIM2;
   localparam int unsigned OW    = (N > 1) ? $clog2(N) : 1;
   localparam int unsigned MAX01 = (DIM0 > DIM1) ? DIM0 : DIM1;
   localparam int unsigned MAXD  = (MAX01 > DIM2) ? MAX01 : DIM2;
   localparam int unsigned IW    = (MAXD > 1) ? $clog2(MAXD) : 1;

   // elaboration-time parameter checks
   if (DIM0 < 2 || DIM1 < 2 || DIM2 < 2) begin : g_bad_dim
      $error("cube_rotate_engine: every axis needs at least two entries");
   end
   if (AW < OW) begin : g_bad_aw
      $error("cube_rotate_engine: address width too small for the cube");
   end
   if (DW % 2 != 0) begin : g_bad_dw
      $error("cube_rotate_engine: word must split into real and imaginary halves");
   end

   logic          busy_q, done_q, rd_done_q;
   rot_mode_e     mode_q;
   logic [AW-1:0] src_base_q, dst_base_q;
   logic          start_ok, rd_fire, walk_last, fin;
   logic [OW-1:0] src_off;

   assign start_ok = start & ~busy_q;
   assign rd_fire  = busy_q & ~rd_done_q & mem_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         done_q     <= 1'b0;
         rd_done_q  <= 1'b0;
         mode_q     <= ROT_FWD;
         src_base_q <= '0;
         dst_base_q <= '0;
      end else begin
         done_q <= fin;
         if (start_ok) begin
            busy_q     <= 1'b1;
            rd_done_q  <= 1'b0;
            mode_q     <= rot_mode_e'(mode);
            src_base_q <= src_base;
            dst_base_q <= dst_base;
         end else begin
            if (rd_fire && walk_last) begin
               rd_done_q <= 1'b1;
            end
            if (fin) begin
               busy_q <= 1'b0;
            end
         end
      end
   end

   cube_walk #(
      .D0 (DIM0), .D1 (DIM1), .D2 (DIM2), .IW (IW), .OW (OW)
   ) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (start_ok),
      .step    (rd_fire),
      .mode    (mode_q),
      .src_off (src_off),
      .last    (walk_last)
   );

   cube_wr_stage #(
      .AW (AW), .OW (OW), .DW (DW)
   ) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start_ok),
      .mem_ready (mem_ready),
      .rd_fire   (rd_fire),
      .rd_last   (walk_last),
      .dst_base  (dst_base_q),
      .rd_data   (rd_data),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .fin       (fin)
   );

   assign busy    = busy_q;
   assign done    = done_q;
   assign rd_en   = rd_fire;
   assign rd_addr = src_base_q + AW'(src_off);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (!rd_en && !wr_en));

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy_q) |=> (busy_q && rd_addr == $past(src_base)));

   p_stall_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ready && busy_q) |=> $stable(rd_addr));

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(wr_en) && !busy_q));

   p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> ($stable(mode_q) && $stable(dst_base_q)));

endmodule

// File: tb/cube_rotate_engine_bench.sv
module cube_rotate_engine_bench;

   localparam int unsigned D0 = 3;
   localparam int unsigned D1 = 4;
   localparam int unsigned D2 = 5;
   localparam int unsigned AW = 9;
   localparam int unsigned DW = 64;
   localparam int unsigned N  = D0 * D1 * D2;
   localparam int unsigned MEMW = 512;

   typedef struct packed {
      logic       md;
      logic [1:0] stall;
      logic [8:0] src;
      logic [8:0] dst;
   } vec_t;

   // mode, stall pattern, source base, destination base
   localparam vec_t VEC [4] = '{
      '{md: 1'b0, stall: 2'd0, src: 9'd0,   dst: 9'd100},
      '{md: 1'b1, stall: 2'd0, src: 9'd0,   dst: 9'd100},
      '{md: 1'b0, stall: 2'd1, src: 9'd300, dst: 9'd40},
      '{md: 1'b1, stall: 2'd2, src: 9'd130, dst: 9'd200}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          mode = 1'b0;
   logic [AW-1:0] src_base = '0;
   logic [AW-1:0] dst_base = '0;
   logic          busy, done;
   logic          mem_ready = 1'b1;
   logic          rd_en, wr_en;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [DW-1:0] rd_data = '0;
   logic [DW-1:0] wr_data;

   logic          tb_we = 1'b0;
   logic [AW-1:0] tb_addr = '0;
   logic [DW-1:0] tb_data = '0;
   logic [DW-1:0] mem [MEMW];

   int checks = 0;
   int errors = 0;
   int stall_kind = 0;
   int stall_viol = 0;
   int tick = 0;

   always #5 clk = ~clk;

   cube_rotate_engine #(
      .DIM0 (D0), .DIM1 (D1), .DIM2 (D2), .AW (AW), .DW (DW)
   ) u_cube_rotate_engine (
      .clk (clk), .rst_n (rst_n), .start (start), .mode (mode),
      .src_base (src_base), .dst_base (dst_base), .busy (busy), .done (done),
      .mem_ready (mem_ready), .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data),
      .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data)
   );

   // memory model: read data updates only on an accepted read
   always @(posedge clk) begin
      if (tb_we) mem[tb_addr] <= tb_data;
      else if (wr_en) mem[wr_addr] <= wr_data;
      if (rd_en) rd_data <= mem[rd_addr];
   end

   // ready pattern driver
   initial begin
      forever begin
         @(posedge clk);
         #1;
         tick++;
         case (stall_kind)
            1:       mem_ready = (tick % 3) != 2;
            2:       mem_ready = ((tick * 7) % 5) >= 2;
            default: mem_ready = 1'b1;
         endcase
      end
   end

   // R7 monitor: no request while not ready
   initial begin
      forever begin
         @(negedge clk);
         if (!mem_ready && (rd_en || wr_en)) stall_viol++;
      end
   end

   // watchdog
   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: run did not end, actual running expected stopped");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   function automatic logic [63:0] val(int n);
      return {32'h5A5A_0000 | 32'(n), 32'(n * 7 + 1)};
   endfunction

   function automatic logic [63:0] bg(int a);
      return 64'hBAD0_0000_0000_0000 | 64'(a);
   endfunction

   task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic fill(input int src);
      for (int a = 0; a < MEMW; a++) begin
         @(posedge clk);
         #1;
         tb_we   = 1'b1;
         tb_addr = AW'(a);
         tb_data = (a >= src && a < src + int'(N)) ? val(a - src) : bg(a);
      end
      @(posedge clk);
      #1;
      tb_we = 1'b0;
   endtask

   task automatic run(input logic md, input int stl, input int src, input int dst, input logic inject);
      int cyc;
      int off;
      stall_kind = 0;
      fill(src);
      stall_viol = 0;
      stall_kind = stl;
      @(posedge clk);
      #1;
      mode = md; src_base = AW'(src); dst_base = AW'(dst); start = 1'b1;
      @(posedge clk);
      #1;
      start = 1'b0;
      mode = ~md; src_base = AW'(src + 7); dst_base = 9'd500;  // changes after start must not matter (R2)
      @(negedge clk);
      cyc = 1;
      chk(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
      if (stl == 0)
         chk(rd_en && rd_addr == AW'(src), "R2 first read address", 64'(rd_addr), 64'(src));
      while (!done && cyc < 4000) begin
         @(posedge clk);
         #1;
         if (inject && cyc == 4) begin
            start = 1'b1; src_base = 9'd300; dst_base = 9'd400;   // R9 ignored start
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      chk(done == 1'b1, "R8 done seen", 64'(done), 64'd1);
      if (stl == 0) chk(cyc == int'(N) + 2, "R10 done cycle", 64'(cyc), 64'(N + 2));
      @(negedge clk);
      chk(!done && !busy, "R8 single pulse and idle", 64'({done, busy}), 64'd0);
      chk(stall_viol == 0, "R7 request while not ready", 64'(stall_viol), 64'd0);
      stall_kind = 0;
      for (int i = 0; i < int'(D0); i++)
         for (int j = 0; j < int'(D1); j++)
            for (int k = 0; k < int'(D2); k++) begin
               off = (md == 1'b0) ? ((j * D2 + k) * D0 + i) : ((k * D0 + i) * D1 + j);
               chk(mem[dst + off] == val((i * D1 + j) * D2 + k),
                   md ? "R4 R6 destination word" : "R3 R6 destination word",
                   mem[dst + off], val((i * D1 + j) * D2 + k));
            end
      chk(mem[dst - 1] == bg(dst - 1), "R5 guard below", mem[dst - 1], bg(dst - 1));
      chk(mem[dst + N] == bg(dst + N), "R5 guard above", mem[dst + N], bg(dst + N));
      chk(mem[src] == val(0), "R6 source intact", mem[src], val(0));
      if (inject) begin
         chk(mem[400] == bg(400), "R9 ignored start wrote nothing", mem[400], bg(400));
      end
   endtask

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(!busy && !done && !rd_en && !wr_en, "R1 outputs in reset",
          64'({busy, done, rd_en, wr_en}), 64'd0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy && !done && !rd_en && !wr_en, "R1 outputs idle after reset",
          64'({busy, done, rd_en, wr_en}), 64'd0);

      // vector table
      for (int v = 0; v < 4; v++) begin
         run(VEC[v].md, int'(VEC[v].stall), int'(VEC[v].src), int'(VEC[v].dst), 1'b0);
      end

      // R9 start while busy
      run(1'b0, 0, 0, 100, 1'b1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule